// File: doc/BRIEF.md
# Event Timer Interrupt Router

This block sits between the comparators of a multi-timer event timer and the system's interrupt fabric. Each timer owns a 64-bit configuration word and a 64-bit message routing word. When a comparator reports a match on a fire strobe, the block decides how that timer's interrupt is delivered. It can post a message write, whose address and data come from the routing word. It can emit a one-cycle pulse on an interrupt-controller pin. It can also raise a level on a pin, which stays asserted until software clears the timer's bit in the shared status word.

Configuration writes are merged a 32-bit half at a time. Read-only capability fields are preserved on every write. A requested pin is checked against the timer's read-only allowed-pin mask, and a route that is not allowed is replaced by 0. When a write changes a timer so that its held level interrupt no longer makes sense, the block drops the level on its own. Fires that arrive together are served one per cycle in ascending timer order. Pin releases are also queued and served one per cycle in ascending order.

Top module: `tir_irq_router`

## Requirements
- R1: A fire on a timer whose interrupt-enable bit (configuration bit 2) is 0 produces no pulse, assert or message strobe and leaves the status word unchanged.
- R2: A fire on a timer whose status bit is already 1 produces no strobe.
- R3: When message-capable (bit 15) and message-enable (bit 14) are both 1, a fire raises `msg_req_o` for one cycle with the address taken from routing bits 63:32 and the data from routing bits 31:0. No pin strobe is raised.
- R4: The pin route is configuration bits 13:9. With route 0 and no message delivery, a fire raises nothing. Pulse and assert strobes always carry a nonzero pin.
- R5: Interrupt type is configuration bit 1. With 0 (edge), a fire gives a one-cycle `pin_pulse_o` and leaves the status bit at 0. With 1 (level), it gives `pin_assert_o` and sets status bit i.
- R6: A status write clears exactly the bits that are written as 1 and are currently set. Each cleared bit yields one `pin_deassert_o` strobe carrying that timer's pin.
- R7: Configuration bits 63:32 are the allowed-pin mask. A write that selects a nonzero pin p whose mask bit p is 0 stores route 0 instead.
- R8: A configuration write changes a 32-bit half only when its lane enable is set (lane bit 0 for bits 31:0, lane bit 1 for bits 63:32). Bits 63:32, 15, 5 and 4 keep their previous values. Bit 8 is always stored as 0.
- R9: If a timer's status bit is set and a configuration write disables it, selects message delivery, selects edge type or changes its pin, the status bit is cleared and the old pin is deasserted. Any other write leaves the status bit set.
- R10: After reset, the status word and the routing words are 0. Each configuration word holds bits 15 and 4 set, bit 5 clear, and an allowed mask of pins 24..31 when the controller has 32 or more pins, the top four pins when it has 20 to 31, and no pins below 20.
- R11: Strobes are registered and appear one clock edge after the cycle that caused them. Simultaneous fires are served one per cycle in ascending timer order, and so are simultaneous deasserts.
- R12: A fire waits, without being lost, while a configuration write to the same timer is in progress or a deassert for it is still queued. It is then served with the updated configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fire_i | input | NT | One-cycle match strobe per timer |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | IW | Timer addressed by the configuration write |
| cfg_lane | input | 2 | Half-word enables: bit 0 low half, bit 1 high half |
| cfg_wdata | input | 64 | Configuration write data, in place |
| rt_we | input | 1 | Routing word write enable |
| rt_sel | input | IW | Timer addressed by the routing write |
| rt_lane | input | 2 | Half-word enables for the routing write |
| rt_wdata | input | 64 | Routing write data, in place |
| sts_we | input | 1 | Status write enable |
| sts_wdata | input | NT | Status write data, 1 clears a set bit |
| rd_sel | input | IW | Timer whose words are shown on the read outputs |
| rd_cfg | output | 64 | Configuration word of the selected timer |
| rd_route | output | 64 | Routing word of the selected timer |
| sts_o | output | NT | Level status word, one bit per timer |
| pin_pulse_o | output | 1 | Edge pulse strobe |
| pin_assert_o | output | 1 | Level assert strobe |
| pin_num_o | output | 5 | Pin for the pulse or assert strobe |
| pin_deassert_o | output | 1 | Level release strobe |
| deassert_num_o | output | 5 | Pin for the release strobe |
| msg_req_o | output | 1 | Message write request strobe |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
Fire, configuration and status effects are all registered once. A stimulus held during one cycle therefore shows its strobe, its status change and its stored configuration right after the next rising edge. Each further event queued behind it appears one edge later. The bench changes inputs on the falling edge and reads results on the following falling edge, so every check falls half a period after the edge that produced its value. The ordering tests then step one more falling edge for each queued event. The stall case is checked twice: it must show nothing at the first sample and the updated strobe at the second.

// File: rtl/tir_pkg.sv
`timescale 1ns/1ps
package tir_pkg;

  localparam int B_LVL    = 1;
  localparam int B_EN     = 2;
  localparam int B_MSGEN  = 14;
  localparam int B_MSGCAP = 15;
  localparam int B_PERCAP = 4;

  // read-only capability fields: mask 63:32, message-capable, 64-bit size, periodic-capable
  localparam logic [63:0] RO_BITS  = {32'hFFFF_FFFF, 32'h0000_8030};
  localparam logic [63:0] FORCE0   = 64'h0000_0000_0000_0100;

  typedef enum logic [1:0] {DLV_NONE, DLV_PULSE, DLV_LEVEL, DLV_MSG} dlv_e;

  function automatic logic [31:0] allowed_pins(input int pins);
    if (pins >= 32)      return 32'hFF00_0000;
    else if (pins >= 20) return 32'hF << (pins - 4);
    else                 return 32'h0;
  endfunction

  function automatic logic [63:0] lane_mask(input logic [1:0] lane);
    return {{32{lane[1]}}, {32{lane[0]}}};
  endfunction

  function automatic logic [63:0] lane_merge(input logic [63:0] old,
                                             input logic [63:0] data,
                                             input logic [1:0]  lane);
    logic [63:0] m;
    m = lane_mask(lane);
    return (old & ~m) | (data & m);
  endfunction

  function automatic logic [4:0] route_of(input logic [63:0] c);
    return c[13:9];
  endfunction

  function automatic logic msg_on(input logic [63:0] c);
    return c[B_MSGCAP] & c[B_MSGEN];
  endfunction

  function automatic logic [4:0] pin_of(input logic [63:0] c);
    return msg_on(c) ? 5'd0 : route_of(c);
  endfunction

  function automatic logic [63:0] cfg_merge(input logic [63:0] old,
                                            input logic [63:0] data,
                                            input logic [1:0]  lane);
    logic [63:0] n;
    logic [31:0] okmask;
    logic [4:0]  r;
    n = lane_merge(old, data, lane);
    n = (n & ~(RO_BITS | FORCE0)) | (old & RO_BITS);
    okmask = n[63:32];
    r = n[13:9];
    if (r != 5'd0 && !okmask[r]) n[13:9] = 5'd0;
    return n;
  endfunction

  function automatic dlv_e classify(input logic [63:0] c);
    if (!c[B_EN])                 return DLV_NONE;
    else if (msg_on(c))           return DLV_MSG;
    else if (route_of(c) == 5'd0) return DLV_NONE;
    else if (!c[B_LVL])           return DLV_PULSE;
    else                          return DLV_LEVEL;
  endfunction

  // a held level cannot survive the new configuration
  function automatic logic must_drop(input logic [63:0] old_c,
                                     input logic [63:0] new_c);
    return !new_c[B_EN] || msg_on(new_c) || !new_c[B_LVL] ||
           (pin_of(new_c) != pin_of(old_c));
  endfunction

endpackage

// File: rtl/tir_cfg_bank.sv
`timescale 1ns/1ps
module tir_cfg_bank
  import tir_pkg::*;
#(
  parameter int NT   = 8,
  parameter int PINS = 24,
  localparam int IW  = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [IW-1:0]        cfg_sel,
  input  logic [1:0]           cfg_lane,
  input  logic [63:0]          cfg_wdata,
  input  logic                 rt_we,
  input  logic [IW-1:0]        rt_sel,
  input  logic [1:0]           rt_lane,
  input  logic [63:0]          rt_wdata,
  output logic [NT-1:0][63:0]  cfg_q,
  output logic [NT-1:0][63:0]  rt_q,
  output logic [NT-1:0]        cfg_hit,
  output logic [NT-1:0]        cfg_drop,
  output logic [NT-1:0][4:0]   cur_pin
);

  localparam logic [31:0] ALLOW   = allowed_pins(PINS);
  localparam logic [63:0] CFG_RST = {ALLOW, 32'h0} | (64'h1 << B_MSGCAP) |
                                    (64'h1 << B_PERCAP);

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    logic [63:0] cfg_r, rt_r, cfg_n;
    logic        hit, rhit;

    assign hit   = cfg_we && (cfg_sel == IW'(t));
    assign rhit  = rt_we && (rt_sel == IW'(t));
    assign cfg_n = cfg_merge(cfg_r, cfg_wdata, cfg_lane);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_r <= CFG_RST;
        rt_r  <= 64'h0;
      end else begin
        if (hit)  cfg_r <= cfg_n;
        if (rhit) rt_r  <= lane_merge(rt_r, rt_wdata, rt_lane);
      end
    end

    assign cfg_q[t]    = cfg_r;
    assign rt_q[t]     = rt_r;
    assign cfg_hit[t]  = hit;
    assign cfg_drop[t] = hit && must_drop(cfg_r, cfg_n);
    assign cur_pin[t]  = pin_of(cfg_r);
  end

endmodule

// File: rtl/tir_status.sv
`timescale 1ns/1ps
module tir_status #(
  parameter int NT  = 8,
  localparam int IW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sts_we,
  input  logic [NT-1:0]       sts_wdata,
  input  logic [NT-1:0]       cfg_drop,
  input  logic [NT-1:0][4:0]  cur_pin,
  input  logic [NT-1:0]       set_vec,
  output logic [NT-1:0]       sts_q,
  output logic [NT-1:0]       dq_busy,
  output logic [NT-1:0]       dq_backlog,
  output logic                deassert_o,
  output logic [4:0]          deassert_num_o
);

  logic [NT-1:0]      dq_q, clr_now, pick_oh;
  logic [NT-1:0][4:0] dpin_q;
  logic [IW-1:0]      idx;
  logic [4:0]         num_n;

  assign clr_now = ((sts_we ? sts_wdata : '0) | cfg_drop) & sts_q;
  assign dq_busy = dq_q | clr_now;
  assign pick_oh = dq_busy & (~dq_busy + 1'b1);
  assign dq_backlog = dq_q;

  always_comb begin
    idx = '0;
    for (int i = NT - 1; i >= 0; i--)
      if (dq_busy[i]) idx = IW'(i);
    num_n = clr_now[idx] ? cur_pin[idx] : dpin_q[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q          <= '0;
      dq_q           <= '0;
      dpin_q         <= '0;
      deassert_o     <= 1'b0;
      deassert_num_o <= 5'd0;
    end else begin
      sts_q          <= (sts_q & ~clr_now) | set_vec;
      dq_q           <= dq_busy & ~pick_oh;
      deassert_o     <= |dq_busy;
      deassert_num_o <= (|dq_busy) ? num_n : 5'd0;
      for (int i = 0; i < NT; i++)
        if (clr_now[i]) dpin_q[i] <= cur_pin[i];
    end
  end

endmodule

// File: rtl/tir_fire_arb.sv
`timescale 1ns/1ps
module tir_fire_arb
  import tir_pkg::*;
#(
  parameter int NT  = 8,
  localparam int IW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NT-1:0]       fire_i,
  input  logic [NT-1:0]       block,
  input  logic [NT-1:0][63:0] cfg_q,
  input  logic [NT-1:0][63:0] rt_q,
  input  logic [NT-1:0]       sts_q,
  output logic [NT-1:0]       set_vec,
  output logic                pulse_o,
  output logic                assert_o,
  output logic [4:0]          pin_num_o,
  output logic                msg_o,
  output logic [31:0]         msg_addr_o,
  output logic [31:0]         msg_data_o
);

  logic [NT-1:0] pend_q, cand, elig, pick_oh;
  logic [IW-1:0] idx;
  logic          any;
  dlv_e          kind;

  assign cand    = pend_q | fire_i;
  assign elig    = cand & ~block;
  assign pick_oh = elig & (~elig + 1'b1);
  assign any     = |elig;

  always_comb begin
    idx = '0;
    for (int i = NT - 1; i >= 0; i--)
      if (elig[i]) idx = IW'(i);
    kind = DLV_NONE;
    if (any && !sts_q[idx]) kind = classify(cfg_q[idx]);
  end

  assign set_vec = (kind == DLV_LEVEL) ? pick_oh : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= '0;
      pulse_o    <= 1'b0;
      assert_o   <= 1'b0;
      pin_num_o  <= 5'd0;
      msg_o      <= 1'b0;
      msg_addr_o <= 32'h0;
      msg_data_o <= 32'h0;
    end else begin
      pend_q    <= cand & ~pick_oh;
      pulse_o   <= (kind == DLV_PULSE);
      assert_o  <= (kind == DLV_LEVEL);
      msg_o     <= (kind == DLV_MSG);
      pin_num_o <= (kind == DLV_PULSE || kind == DLV_LEVEL) ? route_of(cfg_q[idx]) : 5'd0;
      if (kind == DLV_MSG) begin
        msg_addr_o <= rt_q[idx][63:32];
        msg_data_o <= rt_q[idx][31:0];
      end else begin
        msg_addr_o <= 32'h0;
        msg_data_o <= 32'h0;
      end
    end
  end

endmodule

// File: rtl/tir_irq_router.sv
`timescale 1ns/1ps
module tir_irq_router #(
  parameter int NT   = 8,
  parameter int PINS = 24,
  localparam int IW  = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] fire_i,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_sel,
  input  logic [1:0]    cfg_lane,
  input  logic [63:0]   cfg_wdata,
  input  logic          rt_we,
  input  logic [IW-1:0] rt_sel,
  input  logic [1:0]    rt_lane,
  input  logic [63:0]   rt_wdata,
  input  logic          sts_we,
  input  logic [NT-1:0] sts_wdata,
  input  logic [IW-1:0] rd_sel,
  output logic [63:0]   rd_cfg,
  output logic [63:0]   rd_route,
  output logic [NT-1:0] sts_o,
  output logic          pin_pulse_o,
  output logic          pin_assert_o,
  output logic [4:0]    pin_num_o,
  output logic          pin_deassert_o,
  output logic [4:0]    deassert_num_o,
  output logic          msg_req_o,
  output logic [31:0]   msg_addr_o,
  output logic [31:0]   msg_data_o
);

  logic [NT-1:0][63:0] cfg_all, rt_all;
  logic [NT-1:0]       cfg_hit, cfg_drop, set_vec, dq_busy, dq_backlog, fire_block;
  logic [NT-1:0][4:0]  cur_pin;

  tir_cfg_bank #(.NT(NT), .PINS(PINS)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_lane(cfg_lane), .cfg_wdata(cfg_wdata),
    .rt_we(rt_we), .rt_sel(rt_sel), .rt_lane(rt_lane), .rt_wdata(rt_wdata),
    .cfg_q(cfg_all), .rt_q(rt_all), .cfg_hit(cfg_hit), .cfg_drop(cfg_drop),
    .cur_pin(cur_pin)
  );

  tir_status #(.NT(NT)) u_sts (
    .clk(clk), .rst_n(rst_n),
    .sts_we(sts_we), .sts_wdata(sts_wdata),
    .cfg_drop(cfg_drop), .cur_pin(cur_pin), .set_vec(set_vec),
    .sts_q(sts_o), .dq_busy(dq_busy), .dq_backlog(dq_backlog),
    .deassert_o(pin_deassert_o), .deassert_num_o(deassert_num_o)
  );

  // a timer under reconfiguration or awaiting release keeps its fire pending
  assign fire_block = cfg_hit | dq_busy;

  tir_fire_arb #(.NT(NT)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .fire_i(fire_i), .block(fire_block),
    .cfg_q(cfg_all), .rt_q(rt_all), .sts_q(sts_o),
    .set_vec(set_vec),
    .pulse_o(pin_pulse_o), .assert_o(pin_assert_o), .pin_num_o(pin_num_o),
    .msg_o(msg_req_o), .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o)
  );

  assign rd_cfg   = cfg_all[rd_sel];
  assign rd_route = rt_all[rd_sel];

endmodule

// File: rtl/tir_checker.sv
`timescale 1ns/1ps
module tir_checker
  import tir_pkg::*;
#(
  parameter int NT = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NT-1:0][63:0] cfg_all,
  input logic [NT-1:0]       sts_o,
  input logic                pin_pulse_o,
  input logic                pin_assert_o,
  input logic [4:0]          pin_num_o,
  input logic                pin_deassert_o,
  input logic [4:0]          deassert_num_o,
  input logic                msg_req_o
);

  logic [NT-1:0]       level_ok, route_ok;
  logic [NT-1:0][63:0] fixed_v;

  for (genvar t = 0; t < NT; t++) begin : g_v
    logic [31:0] m;
    logic [4:0]  r;
    assign m = cfg_all[t][63:32];
    assign r = cfg_all[t][13:9];
    assign level_ok[t] = cfg_all[t][B_EN] && cfg_all[t][B_LVL] &&
                         !(cfg_all[t][B_MSGCAP] && cfg_all[t][B_MSGEN]) && (r != 5'd0);
    assign route_ok[t] = (r == 5'd0) || m[r];
    assign fixed_v[t]  = cfg_all[t] & (RO_BITS | FORCE0);
  end

  AST_ONE_FIRE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pin_pulse_o, pin_assert_o, msg_req_o})); // R11

  AST_PIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pulse_o || pin_assert_o) |-> (pin_num_o != 5'd0)); // R4

  AST_RELEASE_PIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pin_deassert_o |-> (deassert_num_o != 5'd0)); // R6

  AST_ASSERT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    pin_assert_o |-> ((sts_o & ~$past(sts_o)) != '0)); // R5

  AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(sts_o) & ~sts_o) != '0) |-> pin_deassert_o); // R6

  AST_LEVEL_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_o & ~level_ok) == '0); // R9

  AST_ROUTE_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    route_ok == '1); // R7

  AST_FIXED_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(fixed_v)); // R8

endmodule

bind tir_irq_router tir_checker #(.NT(NT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_all(cfg_all), .sts_o(sts_o),
  .pin_pulse_o(pin_pulse_o), .pin_assert_o(pin_assert_o), .pin_num_o(pin_num_o),
  .pin_deassert_o(pin_deassert_o), .deassert_num_o(deassert_num_o),
  .msg_req_o(msg_req_o)
);

// File: tb/sim_tir_irq_router.sv
`timescale 1ns/1ps
module sim_tir_irq_router;

  localparam int NT = 8;
  localparam int PINS = 24;
  localparam int IW = 3;
  // R10: 20..31 pins -> top four pins allowed
  localparam logic [31:0] EXP_ALLOW = 32'h1 << (PINS - 1) | 32'h1 << (PINS - 2) |
                                      32'h1 << (PINS - 3) | 32'h1 << (PINS - 4);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NT-1:0] fire_i = '0;
  logic cfg_we = 1'b0, rt_we = 1'b0, sts_we = 1'b0;
  logic [IW-1:0] cfg_sel = '0, rt_sel = '0, rd_sel = '0;
  logic [1:0] cfg_lane = 2'b11, rt_lane = 2'b11;
  logic [63:0] cfg_wdata = '0, rt_wdata = '0;
  logic [NT-1:0] sts_wdata = '0;
  logic [63:0] rd_cfg, rd_route;
  logic [NT-1:0] sts_o;
  logic pin_pulse_o, pin_assert_o, pin_deassert_o, msg_req_o;
  logic [4:0] pin_num_o, deassert_num_o;
  logic [31:0] msg_addr_o, msg_data_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tir_irq_router #(.NT(NT), .PINS(PINS)) u0 (.*);

  // stimulus vectors: timer, enable, level, route, message, expected kind, expected pin
  // kind: 0 none, 1 pulse, 2 level assert, 3 message
  localparam int NV = 7;
  localparam int V_T[NV]    = '{0, 1, 2, 3, 4, 5, 7};
  localparam int V_EN[NV]   = '{1, 1, 0, 1, 1, 1, 1};
  localparam int V_LVL[NV]  = '{0, 1, 1, 0, 1, 1, 1};
  localparam int V_RT[NV]   = '{20, 21, 22, 0, 22, 5, 23};
  localparam int V_MSG[NV]  = '{0, 0, 0, 0, 1, 0, 0};
  localparam int V_KIND[NV] = '{1, 2, 0, 0, 3, 0, 2};
  localparam int V_PIN[NV]  = '{20, 21, 0, 0, 0, 0, 23};

  function automatic logic [63:0] mk(int en, int lvl, int rt, int msg);
    return (64'(lvl) << 1) | (64'(en) << 2) | (64'(rt) << 9) | (64'(msg) << 14);
  endfunction

  function automatic logic [2:0] kbits(int k);
    case (k)
      1: return 3'b100;
      2: return 3'b010;
      3: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic strb(string tag, logic [2:0] k, logic [4:0] pin);
    chk(tag, {59'h0, pin_pulse_o, pin_assert_o, msg_req_o, pin_num_o},
        {59'h0, k, pin});
  endtask

  task automatic wcfg(int t, logic [63:0] d, logic [1:0] lane = 2'b11);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = IW'(t); cfg_wdata = d; cfg_lane = lane;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wrt(int t, logic [63:0] d);
    @(negedge clk);
    rt_we = 1'b1; rt_sel = IW'(t); rt_wdata = d; rt_lane = 2'b11;
    @(negedge clk);
    rt_we = 1'b0;
  endtask

  task automatic wsts(logic [NT-1:0] d);
    @(negedge clk);
    sts_we = 1'b1; sts_wdata = d;
    @(negedge clk);
    sts_we = 1'b0;
  endtask

  task automatic fire(logic [NT-1:0] m);
    @(negedge clk);
    fire_i = m;
    @(negedge clk);
    fire_i = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R10 reset state
    rd_sel = 3'd0;
    #0;
    chk("R10 reset cfg", rd_cfg, {EXP_ALLOW, 32'h0000_8010});
    chk("R10 reset route", rd_route, 64'h0);
    chk("R10 reset status", {56'h0, sts_o}, 64'h0);
    strb("R10 reset strobes", 3'b000, 5'd0);

    // table of fire scenarios
    for (int v = 0; v < NV; v++) begin
      wcfg(V_T[v], mk(V_EN[v], V_LVL[v], V_RT[v], V_MSG[v]));
      wrt(V_T[v], {32'hFEE0_0000 + 32'(V_T[v]), 32'h40 + 32'(V_T[v])});
      fire(NT'(1) << V_T[v]);
      strb($sformatf("R1 R3 R4 R5 vec%0d strobe", v), kbits(V_KIND[v]), 5'(V_PIN[v]));
      chk($sformatf("R5 vec%0d status", v), {56'h0, sts_o},
          (V_KIND[v] == 2) ? (64'h1 << V_T[v]) : 64'h0);
      if (V_KIND[v] == 3)
        chk("R3 message words", {msg_addr_o, msg_data_o},
            {32'hFEE0_0000 + 32'(V_T[v]), 32'h40 + 32'(V_T[v])});
      if (V_RT[v] == 5) begin
        rd_sel = IW'(V_T[v]);
        #0;
        chk("R7 invalid route forced to 0", {59'h0, rd_cfg[13:9]}, 64'h0);
      end
      wsts('1);
      chk($sformatf("R6 vec%0d release", v), {58'h0, pin_deassert_o, deassert_num_o},
          (V_KIND[v] == 2) ? {58'h0, 1'b1, 5'(V_PIN[v])} : 64'h0);
      idle(2);
    end

    // R8 read-only fields and forced bit, R7 route out of mask
    wcfg(6, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_sel = 3'd6;
    #0;
    chk("R8 R7 all-ones write", rd_cfg, {EXP_ALLOW, 32'hFFFF_C0DF});
    wcfg(6, mk(1, 0, 22, 0));
    #0;
    chk("R7 allowed route kept", rd_cfg, {EXP_ALLOW, 32'h0000_8010} | mk(1, 0, 22, 0));
    wcfg(6, 64'h0, 2'b10);
    #0;
    chk("R8 high-lane-only write", rd_cfg, {EXP_ALLOW, 32'h0000_8010} | mk(1, 0, 22, 0));

    // R2, R6, R9 on a held level
    wcfg(1, mk(1, 1, 21, 0));
    fire(8'h02);
    strb("R5 level assert", 3'b010, 5'd21);
    fire(8'h02);
    strb("R2 fire while pending", 3'b000, 5'd0);
    wsts(8'h80);
    chk("R6 clear of unset bit", {57'h0, pin_deassert_o, sts_o}, {57'h0, 1'b0, 8'h02});
    wcfg(1, mk(1, 1, 21, 0) | 64'h8);
    chk("R9 harmless change keeps level", {57'h0, pin_deassert_o, sts_o}, {57'h0, 1'b0, 8'h02});
    wcfg(1, mk(1, 1, 20, 0));
    chk("R9 reroute drops level", {52'h0, pin_deassert_o, deassert_num_o, sts_o},
        {52'h0, 1'b1, 5'd21, 8'h00});
    fire(8'h02);
    strb("R9 rerouted assert", 3'b010, 5'd20);
    wcfg(1, mk(0, 1, 20, 0));
    chk("R9 disable drops level", {52'h0, pin_deassert_o, deassert_num_o, sts_o},
        {52'h0, 1'b1, 5'd20, 8'h00});

    // R11 ordering of level asserts and of releases
    wcfg(1, mk(1, 1, 21, 0));
    wcfg(7, mk(1, 1, 23, 0));
    fire(8'h82);
    strb("R11 first assert timer1", 3'b010, 5'd21);
    idle(1);
    strb("R11 second assert timer7", 3'b010, 5'd23);
    chk("R5 both status bits", {56'h0, sts_o}, 64'h82);
    wsts(8'hFF);
    chk("R11 first release", {58'h0, pin_deassert_o, deassert_num_o}, {58'h0, 1'b1, 5'd21});
    idle(1);
    chk("R11 second release", {58'h0, pin_deassert_o, deassert_num_o}, {58'h0, 1'b1, 5'd23});
    chk("R6 status empty", {56'h0, sts_o}, 64'h0);

    // R11 ordering of pulses
    wcfg(2, mk(1, 0, 22, 0));
    wcfg(6, mk(1, 0, 23, 0));
    fire(8'h44);
    strb("R11 first pulse timer2", 3'b100, 5'd22);
    idle(1);
    strb("R11 second pulse timer6", 3'b100, 5'd23);
    chk("R5 edge leaves status", {56'h0, sts_o}, 64'h0);

    // R12 fire during configuration write of the same timer
    wcfg(0, mk(1, 0, 20, 0));
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = mk(1, 0, 21, 0); cfg_lane = 2'b11;
    fire_i = 8'h01;
    @(negedge clk);
    cfg_we = 1'b0; fire_i = '0;
    strb("R12 fire held during write", 3'b000, 5'd0);
    idle(1);
    strb("R12 fire served with new route", 3'b100, 5'd21);

    idle(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule